// File: doc/BRIEF.md
# Oldest-Ready Issue Picker with Age Matrix

This block is the select stage of an out-of-order issue queue with a fixed number of slots. Dispatch logic places an instruction into a free slot through the allocate port. Wakeup logic outside the block raises a per-slot readiness line once that slot's operands are available. In each cycle the block grants at most one slot: the ready slot that was placed earliest. The granted slot is released at the next clock edge, so it can never be granted a second time.

Relative age is not held as a position in a shifting array. The block keeps a square bit matrix. Row `i` lists the slots that were already occupied when slot `i` was filled. That row is captured in one write from the occupancy vector at allocation. At the same time, the new slot's column is cleared in every other row. A slot wins when none of the slots marked older in its row is also requesting. The block exposes the occupancy vector so that dispatch can choose a free slot.

Top module: `age_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, no slot reads busy and `gnt_vld` is low, whatever `entry_rdy` holds.
- R2: An allocation names a free slot by its binary index 0..NUM_ENTRIES-1 on `alloc_idx` with `alloc_vld` high. That slot's `entry_busy` bit reads 1 from the next cycle. Naming a busy slot is illegal.
- R3: A grant goes only to a slot that is busy and ready. Readiness on a free slot has no effect. `gnt_vld` is high in every cycle in which at least one busy slot is ready, and low otherwise.
- R4: Among the busy ready slots, the one allocated earliest is granted, whatever its index value. `gnt_idx` carries that slot's binary index.
- R5: The granted slot's `entry_busy` bit is 0 in the next cycle. The slot is not granted again until it is allocated again.
- R6: A slot allocated in a given cycle cannot win the grant in that same cycle. The grant in that cycle is decided from the state before the allocation.
- R7: A slot freed by a grant may be allocated again from the next cycle. It then ranks as younger than every other busy slot.
- R8: At most one slot is granted per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate a slot this cycle |
| alloc_idx | input | IDX_W | Binary index of the slot to allocate |
| entry_rdy | input | NUM_ENTRIES | Per-slot operands-ready lines |
| gnt_vld | output | 1 | A slot is granted this cycle |
| gnt_idx | output | IDX_W | Binary index of the granted slot |
| entry_busy | output | NUM_ENTRIES | Occupancy vector, one bit per slot |

## Verification
Several properties are checked on every cycle: a grant always lands on a busy, ready slot; the grant is work-conserving; the internal grant vector is at most one-hot; a granted slot is free one cycle later; and an allocation targets a free slot, which then reads busy. Whether the winner is truly the oldest depends on the whole allocation history, so only the bench's scenarios can show it. These cover in-order fills, scrambled fills, reuse of a freed slot that must then rank youngest, allocation in the same cycle as that slot's readiness, and a long pseudo-random run compared against an allocation-order list.

// File: rtl/age_sched_pkg.sv
package age_sched_pkg;

    // Default slot count of the scheduler.
    localparam int unsigned SCHED_ENTRIES = 8;

    // Width of a binary slot index for a given slot count.
    function automatic int unsigned idx_width(input int unsigned entries);
        return (entries > 1) ? $clog2(entries) : 1;
    endfunction

    // Select the phase of a slot within one cycle, used for readability.
    typedef enum logic [1:0] {
        SLOT_FREE    = 2'd0,
        SLOT_WAITING = 2'd1,
        SLOT_READY   = 2'd2
    } slot_phase_e;

endpackage

// File: rtl/age_sched_occupancy.sv
module age_sched_occupancy
    import age_sched_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = SCHED_ENTRIES,
    localparam int unsigned IDX_W      = idx_width(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_vld,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic                   gnt_vld,
    input  logic [IDX_W-1:0]       gnt_idx,
    output logic [NUM_ENTRIES-1:0] busy
);

    localparam logic [NUM_ENTRIES-1:0] ONE = NUM_ENTRIES'(1);

    logic [NUM_ENTRIES-1:0] set_vec;
    logic [NUM_ENTRIES-1:0] clr_vec;
    logic [NUM_ENTRIES-1:0] busy_q;

    always_comb begin
        set_vec = alloc_vld ? (ONE << alloc_idx) : '0;
        clr_vec = gnt_vld   ? (ONE << gnt_idx)   : '0;
    end

    // Release on grant, occupy on allocate; the two never name the same
    // slot in one cycle because allocation must target a free slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~clr_vec) | set_vec;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/age_sched_matrix.sv
module age_sched_matrix
    import age_sched_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = SCHED_ENTRIES,
    localparam int unsigned IDX_W      = idx_width(NUM_ENTRIES),
    localparam int unsigned CELLS      = NUM_ENTRIES * NUM_ENTRIES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_vld,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic [NUM_ENTRIES-1:0] busy,
    output logic [CELLS-1:0]       older_flat
);

    localparam logic [NUM_ENTRIES-1:0] ONE = NUM_ENTRIES'(1);

    logic [NUM_ENTRIES-1:0] new_col_mask;

    // Column of the slot being allocated: cleared in every other row.
    assign new_col_mask = alloc_vld ? ~(ONE << alloc_idx) : '1;

    for (genvar r = 0; r < NUM_ENTRIES; r++) begin : g_row
        localparam logic [NUM_ENTRIES-1:0] SELF = ONE << r;

        logic [NUM_ENTRIES-1:0] row_q;
        logic                   row_write;

        assign row_write = alloc_vld && (alloc_idx == IDX_W'(r));

        // A freshly allocated row records every slot occupied right now as
        // older. Bits of slots released later go stale but are masked by
        // the request vector in the picker and are cleared on reuse.
        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (row_write) begin
                row_q <= busy & ~SELF;
            end else begin
                row_q <= row_q & new_col_mask;
            end
        end

        assign older_flat[r*NUM_ENTRIES +: NUM_ENTRIES] = row_q;
    end

endmodule

// File: rtl/age_sched_picker.sv
module age_sched_picker
    import age_sched_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = SCHED_ENTRIES,
    localparam int unsigned IDX_W      = idx_width(NUM_ENTRIES),
    localparam int unsigned CELLS      = NUM_ENTRIES * NUM_ENTRIES
) (
    input  logic [NUM_ENTRIES-1:0] busy,
    input  logic [NUM_ENTRIES-1:0] rdy,
    input  logic [CELLS-1:0]       older_flat,
    output logic [NUM_ENTRIES-1:0] gnt_vec,
    output logic                   gnt_vld,
    output logic [IDX_W-1:0]       gnt_idx
);

    localparam logic [NUM_ENTRIES-1:0] ONE = NUM_ENTRIES'(1);

    logic [NUM_ENTRIES-1:0] req;
    slot_phase_e            phase [NUM_ENTRIES];

    // Readiness of a free slot is discarded here.
    assign req = busy & rdy;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
        localparam logic [NUM_ENTRIES-1:0] SELF = ONE << e;

        logic [NUM_ENTRIES-1:0] age_row;
        logic                   blocked;

        assign age_row = older_flat[e*NUM_ENTRIES +: NUM_ENTRIES];
        // Every request line fans out to every slot; the diagonal is ignored.
        assign blocked = |(age_row & req & ~SELF);

        always_comb begin
            if (!busy[e])      phase[e] = SLOT_FREE;
            else if (!rdy[e])  phase[e] = SLOT_WAITING;
            else               phase[e] = SLOT_READY;
        end

        assign gnt_vec[e] = (phase[e] == SLOT_READY) && !blocked;
    end

    assign gnt_vld = |gnt_vec;

    // One-hot to binary: OR of the indices of set bits.
    always_comb begin
        gnt_idx = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (gnt_vec[e]) begin
                gnt_idx = gnt_idx | IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/age_sched.sv
module age_sched
    import age_sched_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = SCHED_ENTRIES,
    localparam int unsigned IDX_W      = idx_width(NUM_ENTRIES),
    localparam int unsigned CELLS      = NUM_ENTRIES * NUM_ENTRIES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_vld,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic [NUM_ENTRIES-1:0] entry_rdy,
    output logic                   gnt_vld,
    output logic [IDX_W-1:0]       gnt_idx,
    output logic [NUM_ENTRIES-1:0] entry_busy
);

    logic [NUM_ENTRIES-1:0] busy;
    logic [CELLS-1:0]       older_flat;
    logic [NUM_ENTRIES-1:0] gnt_vec;
    logic                   pick_vld;
    logic [IDX_W-1:0]       pick_idx;

    age_sched_occupancy #(.NUM_ENTRIES(NUM_ENTRIES)) u_occ (
        .clk       (clk),
        .rst       (rst),
        .alloc_vld (alloc_vld),
        .alloc_idx (alloc_idx),
        .gnt_vld   (pick_vld),
        .gnt_idx   (pick_idx),
        .busy      (busy)
    );

    age_sched_matrix #(.NUM_ENTRIES(NUM_ENTRIES)) u_mat (
        .clk        (clk),
        .rst        (rst),
        .alloc_vld  (alloc_vld),
        .alloc_idx  (alloc_idx),
        .busy       (busy),
        .older_flat (older_flat)
    );

    // Decided from registered state only, so a same-cycle allocation
    // cannot take part in this cycle's selection.
    age_sched_picker #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .busy       (busy),
        .rdy        (entry_rdy),
        .older_flat (older_flat),
        .gnt_vec    (gnt_vec),
        .gnt_vld    (pick_vld),
        .gnt_idx    (pick_idx)
    );

    assign gnt_vld    = pick_vld;
    assign gnt_idx    = pick_idx;
    assign entry_busy = busy;

endmodule

// File: rtl/age_sched_chk.sv
module age_sched_chk
    import age_sched_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = SCHED_ENTRIES,
    localparam int unsigned IDX_W      = idx_width(NUM_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   alloc_vld,
    input logic [IDX_W-1:0]       alloc_idx,
    input logic [NUM_ENTRIES-1:0] entry_rdy,
    input logic                   gnt_vld,
    input logic [IDX_W-1:0]       gnt_idx,
    input logic [NUM_ENTRIES-1:0] entry_busy,
    input logic [NUM_ENTRIES-1:0] gnt_vec
);

    a_r3_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> (entry_busy[gnt_idx] && entry_rdy[gnt_idx]));

    a_r3_grant_when_any: assert property (@(posedge clk) disable iff (rst)
        (|(entry_busy & entry_rdy)) |-> gnt_vld);

    a_r3_idle_when_none: assert property (@(posedge clk) disable iff (rst)
        !(|(entry_busy & entry_rdy)) |-> !gnt_vld);

    a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_vec));

    a_r5_released: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |=> !entry_busy[$past(gnt_idx)]);

    a_r2_alloc_free: assert property (@(posedge clk) disable iff (rst)
        alloc_vld |-> !entry_busy[alloc_idx]);

    a_r2_alloc_marks: assert property (@(posedge clk) disable iff (rst)
        alloc_vld |=> entry_busy[$past(alloc_idx)]);

    a_r6_new_not_picked: assert property (@(posedge clk) disable iff (rst)
        (alloc_vld && gnt_vld) |-> (gnt_idx != alloc_idx));

endmodule

bind age_sched age_sched_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alloc_vld  (alloc_vld),
    .alloc_idx  (alloc_idx),
    .entry_rdy  (entry_rdy),
    .gnt_vld    (gnt_vld),
    .gnt_idx    (gnt_idx),
    .entry_busy (entry_busy),
    .gnt_vec    (gnt_vec)
);

// File: tb/age_sched_test.sv
module age_sched_test;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          alloc_vld;
    logic [IW-1:0] alloc_idx;
    logic [N-1:0]  entry_rdy;
    wire           gnt_vld;
    wire  [IW-1:0] gnt_idx;
    wire  [N-1:0]  entry_busy;

    always #4 clk = ~clk;   // 125 MHz

    age_sched #(.NUM_ENTRIES(N)) uut (
        .clk        (clk),
        .rst        (rst),
        .alloc_vld  (alloc_vld),
        .alloc_idx  (alloc_idx),
        .entry_rdy  (entry_rdy),
        .gnt_vld    (gnt_vld),
        .gnt_idx    (gnt_idx),
        .entry_busy (entry_busy)
    );

    int vectors = 0;
    int errors  = 0;

    // Reference: busy slots listed oldest first.
    int           order_q[$];
    // Scoreboard of expected results, one item per driven cycle.
    bit           exp_v_q[$];
    int           exp_i_q[$];
    logic [N-1:0] exp_b_q[$];
    string        exp_t_q[$];

    function automatic bit is_busy(input int s);
        foreach (order_q[k]) if (order_q[k] == s) return 1'b1;
        return 1'b0;
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic cyc(input bit av, input int ai, input logic [N-1:0] r,
                       input string tag);
        bit           gv;
        int           gi;
        logic [N-1:0] b;
        @(negedge clk);
        alloc_vld = av;
        alloc_idx = IW'(ai);
        entry_rdy = r;
        b  = '0;
        foreach (order_q[k]) b[order_q[k]] = 1'b1;
        gv = 1'b0;
        gi = 0;
        foreach (order_q[k]) begin
            if (!gv && r[order_q[k]]) begin
                gv = 1'b1;
                gi = order_q[k];
            end
        end
        exp_v_q.push_back(gv);
        exp_i_q.push_back(gi);
        exp_b_q.push_back(b);
        exp_t_q.push_back(tag);
        if (gv) begin
            for (int k = 0; k < order_q.size(); k++) begin
                if (order_q[k] == gi) begin
                    order_q.delete(k);
                    break;
                end
            end
        end
        if (av) order_q.push_back(ai);
    endtask

    // Monitor: compare mid-cycle, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_v_q.size() > 0) begin
                bit           ev;
                int           ei;
                logic [N-1:0] eb;
                string        et;
                ev = exp_v_q.pop_front();
                ei = exp_i_q.pop_front();
                eb = exp_b_q.pop_front();
                et = exp_t_q.pop_front();
                vectors++;
                if (entry_busy !== eb) begin
                    errors++;
                    $display("FAIL %s busy: actual %b expected %b", et, entry_busy, eb);
                end
                if (gnt_vld !== ev) begin
                    errors++;
                    $display("FAIL %s gnt_vld: actual %b expected %b", et, gnt_vld, ev);
                end else if (ev && (gnt_idx !== IW'(ei))) begin
                    errors++;
                    $display("FAIL %s gnt_idx: actual %0d expected %0d", et, gnt_idx, ei);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst       = 1'b1;
        alloc_vld = 1'b0;
        alloc_idx = '0;
        entry_rdy = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: nothing busy, nothing granted despite all ready lines high.
        cyc(0, 0, '1, "R1");

        // R2: fill slots 0..3 in order; R3: nothing ready, no grant.
        for (int s = 0; s < 4; s++) cyc(1, s, '0, "R2 R3");
        // R3: readiness only on free slots is ignored.
        cyc(0, 0, 8'hF0, "R3");
        // R4 R8: slots 1 and 3 ready, slot 1 is older.
        cyc(0, 0, 8'h0A, "R4 R8");
        // R5: slot 1 released, so slot 3 now wins.
        cyc(0, 0, 8'h0A, "R5");
        // R7: reuse slot 1 while slot 0 is granted.
        cyc(1, 1, 8'h01, "R7");
        // R7: slot 2 older than reused slot 1 despite larger index.
        cyc(0, 0, 8'h06, "R7 R4");
        cyc(0, 0, 8'h06, "R5");
        cyc(0, 0, '0, "R5");

        // R6: allocate slot 5 while its ready line is already high.
        cyc(1, 5, 8'h20, "R6");
        cyc(0, 0, 8'h20, "R6");
        cyc(0, 0, '1, "R5");

        // R4: scrambled fill, then drain with every line high.
        begin
            int fill[8] = '{7, 4, 6, 2, 0, 3, 1, 5};
            foreach (fill[k]) cyc(1, fill[k], '0, "R2");
        end
        for (int k = 0; k < 8; k++) cyc(0, 0, '1, "R4 R5");
        cyc(0, 0, '1, "R3");

        // R6: allocate and grant in the same cycle.
        cyc(1, 3, '0, "R2");
        cyc(1, 6, 8'h48, "R6");
        cyc(1, 3, 8'h48, "R7");
        cyc(0, 0, 8'h48, "R7 R4");
        cyc(0, 0, '0, "R3");

        // R4: pseudo-random stream checked against allocation order.
        lfsr = 16'hACE1;
        for (int t = 0; t < 600; t++) begin
            bit av;
            int ai;
            av = 1'b0;
            ai = 0;
            if (lfsr[8] && order_q.size() < N) begin
                for (int d = 0; d < N; d++) begin
                    int s;
                    s = (int'(lfsr[11:9]) + d) % N;
                    if (!av && !is_busy(s)) begin
                        av = 1'b1;
                        ai = s;
                    end
                end
            end
            cyc(av, ai, lfsr[7:0] & lfsr[15:8], "R4");
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        @(negedge clk);
        alloc_vld = 1'b0;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule